// File: doc/BRIEF.md
# Single-Packet Transmit Frame Sequencer

This block holds exactly one outgoing Ethernet frame at a time. A bus master loads the frame as 32-bit words into a word store and then raises a one-cycle start strobe. The block checks the length the frame declares. A valid frame is then streamed out one byte at a time over a valid/ready handshake. The busy output acts as the readable transmit-request flag. It stays high from the accepted start until the final byte is taken, and while it is high further loads and start strobes are dropped.

The first stored word carries the payload length, that is the frame size minus the 14 header bytes, in its low half. Its upper half carries the first two destination bytes. Every later word is little-endian. Two optional modes are sampled at the start strobe. One extends short frames with zero bytes up to 60 bytes. The other appends a CRC-32 frame check sequence.

The block reports each finished frame with a done pulse. A frame that is rejected at start produces an error pulse instead, and no byte is sent.

Top module: `txq_frame_engine`

## Requirements
- R1: While reset is asserted and right after it is released, tx_busy, out_valid, done_evt and err_evt are all 0.
- R2: Word 0 carries the payload length in bits 15:0, so the frame length is that value plus 14. Bits 23:16 hold the first byte sent and bits 31:24 hold the second.
- R3: Every later word is sent from bits 7:0 upward. A final word that holds 1, 2 or 3 bytes contributes only its low bytes.
- R4: A start strobe taken while idle with a valid frame sets tx_busy on the next cycle. tx_busy stays 1 until the byte flagged out_last is accepted. In the cycle after that acceptance tx_busy is 0 and done_evt is 1 for one cycle.
- R5: The block sends exactly length+14 stored bytes in store order, and out_last marks the final byte of the whole output.
- R6: When pad_mode was 1 at start and the frame is shorter than 60 bytes, zero bytes follow the stored bytes until 60 bytes have been sent. Frames of 60 bytes or more, and frames sent with pad_mode 0, get no padding.
- R7: When fcs_mode was 1 at start, four check bytes follow the frame and any padding. They are the complement of the CRC-32 of all those bytes (reflected polynomial 0xEDB88320, initial value all ones), least significant byte first.
- R8: The start is rejected when no word was loaded, when the frame length exceeds 2046, or when it exceeds the bytes held by the loaded words (4 per word minus 2). A rejected start gives one err_evt pulse, no out_valid and no tx_busy.
- R9: Word writes and start strobes that arrive while tx_busy is 1 have no effect on the frame being sent.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last stay unchanged.
- R11: Every start strobe taken while idle empties the word store, whether it is accepted or rejected. The next frame therefore loads from word 0, and a start with nothing loaded is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store one word |
| wr_data | input | 32 | Word to store |
| tx_go | input | 1 | Start strobe (transmit request) |
| pad_mode | input | 1 | Pad short frames to 60 bytes, sampled at start |
| fcs_mode | input | 1 | Append CRC-32 check bytes, sampled at start |
| tx_busy | output | 1 | Request flag, high while a frame is pending |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |
| done_evt | output | 1 | One-cycle pulse when a frame has finished |
| err_evt | output | 1 | One-cycle pulse when a start is rejected |

## Verification
The hardest case to reach is a word write that arrives while a frame is still in flight. Because the store is emptied at start, a wrongly accepted write would overwrite the head of the frame before it leaves. The bench stalls the consumer right after start, pushes junk words and a second start strobe, and only then drains the frame and compares every byte. Length rejection is driven at both edges: a declared length one byte past the loaded data, and a 2047-byte frame with the store full, next to an accepted 2046-byte frame.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_BODY = 2'd1,
    SQ_FCS  = 2'd2
  } sq_state_e;

  localparam logic [31:0] CRC_REFL_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT      = 32'hFFFF_FFFF;
  localparam int          HDR_BYTES     = 14;
endpackage

// File: rtl/txq_crc_step.sv
module txq_crc_step (
  input  logic [31:0] crc_in,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_out
);
  import txq_pkg::*;

  logic [31:0] acc;

  // one byte through the reflected CRC-32, one bit per iteration
  always_comb begin
    acc = crc_in ^ {24'd0, byte_in};
    for (int b = 0; b < 8; b++) begin
      acc = acc[0] ? ((acc >> 1) ^ CRC_REFL_POLY) : (acc >> 1);
    end
    crc_out = acc;
  end
endmodule

// File: rtl/txq_word_store.sv
module txq_word_store #(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = 9,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic              clear,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_word,
  output logic [15:0]       head_len,
  output logic [CNT_W-1:0]  nwords
);
  logic [31:0]      mem [DEPTH];
  logic [CNT_W-1:0] wptr_q, wptr_d;
  logic             wr_ok;

  assign wr_ok = we && !clear && (wptr_q < CNT_W'(DEPTH));

  always_comb begin
    wptr_d = wptr_q;
    if (clear)      wptr_d = '0;
    else if (wr_ok) wptr_d = wptr_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= '0;
    else        wptr_q <= wptr_d;
  end

  // data array carries no reset
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q[ADDR_W-1:0]] <= wdata;
  end

  assign rd_word  = mem[rd_addr];
  assign head_len = mem[0][15:0];
  assign nwords   = wptr_q;
endmodule

// File: rtl/txq_byte_seq.sv
module txq_byte_seq #(
  parameter int MAX_FRAME = 2046,
  parameter int MIN_BODY  = 60,
  parameter int ADDR_W    = 9,
  parameter int CNT_W     = 10,
  parameter int LEN_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              pad_mode,
  input  logic              fcs_mode,
  input  logic [15:0]       head_len,
  input  logic [CNT_W-1:0]  nwords,
  input  logic [31:0]       rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              consume,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              done_evt,
  output logic              err_evt
);
  import txq_pkg::*;

  localparam int IDX_W = ADDR_W + 2;
  localparam int CMP_W = 18;

  sq_state_e        st_q, st_d;
  logic [LEN_W-1:0] pos_q, pos_d, flen_q, flen_d, body_len;
  logic [1:0]       fidx_q, fidx_d;
  logic [31:0]      crc_q, crc_d, crc_nx, fcs_all;
  logic             pad_q, pad_d, fcs_q, fcs_d, done_q, done_d, err_q, err_d;
  logic [CMP_W-1:0] flen_req, avail;
  logic             pkt_ok, fire, body_end;
  logic [IDX_W-1:0] byte_idx;
  logic [1:0]       lane;
  logic [7:0]       stored_b, body_b, fcs_b;

  // length check on the head word at start
  assign flen_req = CMP_W'(head_len) + CMP_W'(HDR_BYTES);
  assign avail    = (CMP_W'(nwords) << 2) - CMP_W'(2);
  assign pkt_ok   = (nwords != '0) && (flen_req <= CMP_W'(MAX_FRAME)) &&
                    (flen_req <= avail);

  // byte addressing: the two length bytes precede frame byte 0
  assign byte_idx = IDX_W'(pos_q) + IDX_W'(2);
  assign rd_addr  = byte_idx[IDX_W-1:2];
  assign lane     = byte_idx[1:0];
  assign stored_b = rd_word[8*lane +: 8];
  assign body_b   = (pos_q < flen_q) ? stored_b : 8'h00;
  assign body_len = (pad_q && (flen_q < LEN_W'(MIN_BODY))) ? LEN_W'(MIN_BODY) : flen_q;
  assign body_end = (pos_q == body_len - LEN_W'(1));
  assign fcs_all  = ~crc_q;
  assign fcs_b    = fcs_all[8*fidx_q +: 8];

  txq_crc_step u_crc (
    .crc_in (crc_q),
    .byte_in(body_b),
    .crc_out(crc_nx)
  );

  assign out_valid = (st_q != SQ_IDLE);
  assign busy      = (st_q != SQ_IDLE);
  assign out_data  = (st_q == SQ_FCS) ? fcs_b : body_b;
  assign out_last  = ((st_q == SQ_BODY) && body_end && !fcs_q) ||
                     ((st_q == SQ_FCS) && (fidx_q == 2'd3));
  assign fire      = out_valid && out_ready;
  assign consume   = (st_q == SQ_IDLE) && go;
  assign done_evt  = done_q;
  assign err_evt   = err_q;

  always_comb begin
    st_d   = st_q;
    pos_d  = pos_q;
    flen_d = flen_q;
    fidx_d = fidx_q;
    crc_d  = crc_q;
    pad_d  = pad_q;
    fcs_d  = fcs_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (go) begin
          if (pkt_ok) begin
            st_d   = SQ_BODY;
            pos_d  = '0;
            fidx_d = '0;
            flen_d = LEN_W'(flen_req);
            crc_d  = CRC_INIT;
            pad_d  = pad_mode;
            fcs_d  = fcs_mode;
          end else begin
            err_d = 1'b1;
          end
        end
      end
      SQ_BODY: begin
        if (fire) begin
          crc_d = crc_nx;
          pos_d = pos_q + LEN_W'(1);
          if (body_end) begin
            if (fcs_q) begin
              st_d = SQ_FCS;
            end else begin
              st_d   = SQ_IDLE;
              done_d = 1'b1;
            end
          end
        end
      end
      SQ_FCS: begin
        if (fire) begin
          fidx_d = fidx_q + 2'd1;
          if (fidx_q == 2'd3) begin
            st_d   = SQ_IDLE;
            done_d = 1'b1;
          end
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      pos_q  <= '0;
      flen_q <= '0;
      fidx_q <= '0;
      crc_q  <= CRC_INIT;
      pad_q  <= 1'b0;
      fcs_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pos_q  <= pos_d;
      flen_q <= flen_d;
      fidx_q <= fidx_d;
      crc_q  <= crc_d;
      pad_q  <= pad_d;
      fcs_q  <= fcs_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end
endmodule

// File: rtl/txq_frame_engine.sv
module txq_frame_engine #(
  parameter int DEPTH     = 512,
  parameter int MAX_FRAME = 2046,
  parameter int MIN_BODY  = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        tx_go,
  input  logic        pad_mode,
  input  logic        fcs_mode,
  output logic        tx_busy,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        done_evt,
  output logic        err_evt
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int LEN_W  = $clog2(MAX_FRAME + 1);

  logic [ADDR_W-1:0] rd_addr;
  logic [31:0]       rd_word;
  logic [15:0]       head_len;
  logic [CNT_W-1:0]  nwords;
  logic              consume, busy_i, store_we;

  // loads are dropped while a frame is pending
  assign store_we = wr_en && !busy_i;
  assign tx_busy  = busy_i;

  txq_word_store #(
    .DEPTH (DEPTH),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (store_we),
    .wdata   (wr_data),
    .clear   (consume),
    .rd_addr (rd_addr),
    .rd_word (rd_word),
    .head_len(head_len),
    .nwords  (nwords)
  );

  txq_byte_seq #(
    .MAX_FRAME(MAX_FRAME),
    .MIN_BODY (MIN_BODY),
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .LEN_W    (LEN_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (tx_go),
    .pad_mode (pad_mode),
    .fcs_mode (fcs_mode),
    .head_len (head_len),
    .nwords   (nwords),
    .rd_word  (rd_word),
    .rd_addr  (rd_addr),
    .consume  (consume),
    .busy     (busy_i),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_last (out_last),
    .done_evt (done_evt),
    .err_evt  (err_evt)
  );
endmodule

// File: rtl/txq_frame_engine_chk.sv
module txq_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_go,
  input logic       tx_busy,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       done_evt,
  input logic       err_evt
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R10

  AST_START_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_go)); // R4

  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (done_evt && !tx_busy)); // R4

  AST_DONE_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $past(out_valid && out_ready && out_last)); // R5

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> (!tx_busy && !out_valid)); // R8

  AST_ERR_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> $past(tx_go && !tx_busy)); // R8

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && err_evt)); // R4
endmodule

bind txq_frame_engine txq_frame_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tx_go    (tx_go),
  .tx_busy  (tx_busy),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last),
  .done_evt (done_evt),
  .err_evt  (err_evt)
);

// File: tb/txq_frame_engine_test.sv
module txq_frame_engine_test;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, tx_go, pad_mode, fcs_mode, out_ready;
  logic [31:0] wr_data;
  logic        tx_busy, out_valid, out_last, done_evt, err_evt;
  logic [7:0]  out_data;

  int n_chk = 0, n_bad = 0, done_cnt = 0, err_cnt = 0, vcnt = 0;
  bit finished = 0;
  logic [7:0] got_b [0:2100];
  logic [7:0] exp_b [0:2100];

  always #5 clk = ~clk;

  txq_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .tx_go(tx_go),
    .pad_mode(pad_mode), .fcs_mode(fcs_mode), .tx_busy(tx_busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done_evt(done_evt), .err_evt(err_evt)
  );

  // {payload length, bytes written after the length field, pad, fcs, seed}
  localparam logic [37:0] VECS [10] = '{
    {16'd46,  12'd60, 1'b0, 1'b0, 8'h11},
    {16'd0,   12'd14, 1'b1, 1'b1, 8'h22},
    {16'd1,   12'd15, 1'b0, 1'b1, 8'h33},
    {16'd3,   12'd17, 1'b1, 1'b0, 8'h44},
    {16'd100, 12'd50, 1'b0, 1'b0, 8'h55},
    {16'd50,  12'd64, 1'b1, 1'b1, 8'h66},
    {16'd2,   12'd17, 1'b0, 1'b0, 8'h77},
    {16'd4,   12'd18, 1'b1, 1'b1, 8'h88},
    {16'd5,   12'd18, 1'b0, 1'b0, 8'h99},
    {16'd46,  12'd60, 1'b1, 1'b1, 8'hAA}
  };

  always @(negedge clk) begin
    if (done_evt)  done_cnt++;
    if (err_evt)   err_cnt++;
    if (out_valid) vcnt++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input int k, input logic [7:0] seed);
    return 8'((k * 13) + (seed * 5) + 1);
  endfunction

  function automatic logic [31:0] crc8(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic write_word(input logic [31:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2, R3: length in the low half of word 0, then little-endian bytes
  task automatic load(input logic [15:0] plen, input int nbytes, input logic [7:0] seed);
    logic [7:0] bb [0:2051];
    int words = (nbytes + 5) / 4;
    for (int i = 0; i < words * 4; i++) bb[i] = 8'h00;
    bb[0] = plen[7:0]; bb[1] = plen[15:8];
    for (int k = 0; k < nbytes; k++) bb[k + 2] = fbyte(k, seed);
    for (int w = 0; w < words; w++)
      write_word({bb[4*w+3], bb[4*w+2], bb[4*w+1], bb[4*w]});
  endtask

  task automatic pulse_go(input bit pad, input bit fcs);
    pad_mode = pad; fcs_mode = fcs; tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
  endtask

  task automatic collect(output int n);
    n = 0;
    for (int cyc = 0; cyc < 8000; cyc++) begin
      out_ready = (cyc % 3) != 1;
      if (out_valid && out_ready) begin
        got_b[n] = out_data;
        n++;
        if (out_last) begin
          @(negedge clk);
          out_ready = 1'b0;
          return;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  function automatic int build_exp(input int flen, input bit pad, input bit fcs,
                                   input logic [7:0] seed);
    int n = 0;
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < flen; k++) begin exp_b[n] = fbyte(k, seed); n++; end
    if (pad) while (n < 60) begin exp_b[n] = 8'h00; n++; end
    if (fcs) begin
      for (int j = 0; j < n; j++) c = crc8(c, exp_b[j]);
      c = ~c;
      for (int j = 0; j < 4; j++) begin exp_b[n] = c[8*j +: 8]; n++; end
    end
    return n;
  endfunction

  task automatic compare_frame(input int n, input int nexp, input string tag);
    int bad_at = -1;
    check(n == nexp, {tag, " byte count R5"}, n, nexp);
    for (int i = 0; i < nexp && i < n; i++)
      if (bad_at < 0 && got_b[i] !== exp_b[i]) bad_at = i;
    check(bad_at < 0, {tag, " byte content R2/R3/R5"},
          (bad_at < 0) ? 0 : int'(got_b[bad_at]), (bad_at < 0) ? 0 : int'(exp_b[bad_at]));
  endtask

  task automatic expect_reject(input string tag);
    int e0 = err_cnt, v0 = vcnt;
    repeat (2) @(negedge clk);
    check(err_cnt - e0 == 1, {tag, " err pulse R8"}, err_cnt - e0, 1);
    check(vcnt == v0 && !tx_busy, {tag, " nothing sent R8"}, vcnt - v0, 0);
  endtask

  task automatic run_vec(input logic [15:0] plen, input int nbytes, input bit pad,
                         input bit fcs, input logic [7:0] seed, input string tag);
    int flen = int'(plen) + 14;
    int words = (nbytes + 5) / 4;
    int avail = words * 4 - 2;
    int d0, n, nexp;
    string t;
    t = {tag, (pad ? " pad R6" : ""), (fcs ? " fcs R7" : "")};
    load(plen, nbytes, seed);
    d0 = done_cnt;
    pulse_go(pad, fcs);
    if (words == 0 || flen > 2046 || flen > avail) begin
      expect_reject(t);
    end else begin
      check(tx_busy == 1'b1, {t, " busy after go R4"}, tx_busy, 1);
      collect(n);
      nexp = build_exp(flen, pad, fcs, seed);
      compare_frame(n, nexp, t);
      @(negedge clk);
      check(done_cnt - d0 == 1 && !tx_busy, {t, " done and idle R4"}, done_cnt - d0, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n, nexp, d0, v0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tx_go = 1'b0;
    pad_mode = 1'b0; fcs_mode = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!tx_busy && !out_valid && !done_evt && !err_evt, "reset held R1",
          {tx_busy, out_valid, done_evt, err_evt}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_busy && !out_valid && !done_evt && !err_evt, "after reset R1",
          {tx_busy, out_valid, done_evt, err_evt}, 0);

    for (int i = 0; i < 10; i++)
      run_vec(VECS[i][37:22], int'(VECS[i][21:10]), VECS[i][9], VECS[i][8],
              VECS[i][7:0], $sformatf("vec%0d", i));

    // largest accepted frame, then one byte over with the store full
    run_vec(16'd2032, 2046, 1'b0, 1'b1, 8'h3C, "max 2046 R8");
    run_vec(16'd2033, 2046, 1'b0, 1'b0, 8'h3D, "over 2046 R8");

    // R11: the rejected start emptied the store
    pulse_go(1'b0, 1'b0);
    expect_reject("empty after reject R11");

    // R9: loads and a second start while busy are dropped
    load(16'd10, 24, 8'h5A);
    out_ready = 1'b0;
    d0 = done_cnt;
    pulse_go(1'b1, 1'b1);
    write_word(32'hDEADBEEF);
    write_word(32'hCAFEF00D);
    write_word(32'h0BADC0DE);
    pulse_go(1'b0, 1'b0);
    collect(n);
    nexp = build_exp(24, 1'b1, 1'b1, 8'h5A);
    compare_frame(n, nexp, "writes while busy R9");
    v0 = vcnt;
    repeat (4) @(negedge clk);
    check(done_cnt - d0 == 1 && vcnt == v0, "single frame for two starts R9",
          done_cnt - d0, 1);

    // R11: the accepted start also consumed the store
    pulse_go(1'b0, 1'b0);
    expect_reject("empty after send R11");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule